// File: doc/BRIEF.md
# Saturating Motion Delta Accumulator

This block sits between a per-frame displacement estimator and a register-mapped host port. Each frame, the estimator may deliver a signed X and Y step with a valid strobe. The block adds these steps into wide signed accumulators, one per axis. It presents each accumulator to the host as an 8-bit two's-complement delta. When the accumulated value does not fit in 8 bits, the delta shows the full-scale value in the direction of the motion.

The host drains pending motion by reading the delta registers. Each read removes exactly the value it reported, so a large displacement comes out as a run of full-scale reads followed by one remainder. The block keeps two status flags. A motion flag marks unreported movement, and a sticky overflow flag marks that an accumulator hit its limit and lost path data. An active-low interrupt pin follows the motion flag. Any write to the motion register discards all pending motion at once.

A resolution select sets the accumulator range. At the lower resolution the range is half as wide as at the higher one.

Top module: `motion_delta_accum`

## Requirements
- R1: After reset, statusByte is 0x00, deltaX and deltaY read 0x00, and motionN is 1.
- R2: statusByte carries the motion flag in bit 7 and the overflow flag in bit 4. Bits 6, 5 and 3:0 are always 0.
- R3: deltaX and deltaY show the 8-bit two's-complement value of their accumulator when it lies in [-128, 127]. Otherwise they show 0x7F for a larger positive value and 0x80 for a more negative value.
- R4: A cycle with rdDeltaX (rdDeltaY) high subtracts the value currently shown on deltaX (deltaY) from that axis's accumulator. Repeated reads therefore drain any accumulated value to zero.
- R5: A cycle with frameValid high adds the sign-extended frameDx and frameDy to the accumulators. If either step is nonzero, the motion flag is set.
- R6: Accumulators clamp instead of wrapping. With hiRes=1 the range is [-4096, 4095]; with hiRes=0 it is [-2048, 2047]. Any clamp sets the overflow flag.
- R7: The overflow flag stays set until a delta read leaves both accumulators in [-128, 127]. A clamp in that same cycle keeps it set.
- R8: A cycle with wrMotion high zeroes both accumulators and clears both flags. A frame in the same cycle is added after the clear, and no data value is taken.
- R9: motionN is 0 exactly when the motion flag is set.
- R10: The motion flag clears when a delta read leaves both accumulators at zero, unless a nonzero frame arrives in that same cycle.
- R11: A frame arriving in the same cycle as a delta read is added after the reported value is subtracted, so no motion is lost.
- R12: rdMotion alone changes neither the flags nor the deltas.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hiRes | input | 1 | 1 selects the wide accumulator range, 0 the narrow one |
| frameValid | input | 1 | A frame step is present this cycle |
| frameDx | input | 8 | Signed X step of the frame |
| frameDy | input | 8 | Signed Y step of the frame |
| rdMotion | input | 1 | Host reads the status byte |
| rdDeltaY | input | 1 | Host reads the Y delta |
| rdDeltaX | input | 1 | Host reads the X delta |
| wrMotion | input | 1 | Host writes the motion register |
| statusByte | output | 8 | Flags: bit 7 motion, bit 4 overflow |
| deltaY | output | 8 | Saturated Y delta |
| deltaX | output | 8 | Saturated X delta |
| motionN | output | 1 | Motion interrupt, active low |

## Verification
Some properties are checked by assertions on every cycle:
- a write always leaves the overflow flag clear;
- the motion flag falls only after a read or a write;
- the overflow flag rises only in a cycle where a clamp occurred;
- a nonzero frame always leaves the motion flag set;
- a bare status read never changes the motion flag;
- a drain read never flips the sign of an accumulator.

Other behaviour can only be shown by the bench scenarios, which compare against an independent model:
- the exact values returned during multi-read drains;
- the clamp limits under each resolution;
- when the overflow flag clears during a drain;
- a frame arriving in the same cycle as a read.

// File: rtl/mda_pkg.sv
package mda_pkg;

  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic clrAcc;    // zero both accumulators before anything else
    logic subX;      // remove the reported X delta
    logic subY;      // remove the reported Y delta
    logic addFrame;  // add the frame step after clear/subtract
  } mda_strobe_t;

  localparam int AXIS_X = 0;
  localparam int AXIS_Y = 1;
  localparam int NUM_AXES = 2;

endpackage

// File: rtl/mda_axis.sv
module mda_axis #(
  parameter int ACC_W   = 13,
  parameter int DELTA_W = 8,
  parameter int IN_W    = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hiRes,
  input  logic                      clr,
  input  logic                      sub,
  input  logic                      add,
  input  logic signed [IN_W-1:0]    frameD,
  output logic signed [DELTA_W-1:0] report,
  output logic                      satHit,
  output logic                      zeroNext,
  output logic                      fitNext
);

  localparam int EXT_W = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] HI_MAX  = EXT_W'((2 ** (ACC_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] HI_MIN  = EXT_W'(-(2 ** (ACC_W - 1)));
  localparam logic signed [EXT_W-1:0] LO_MAX  = EXT_W'((2 ** (ACC_W - 2)) - 1);
  localparam logic signed [EXT_W-1:0] LO_MIN  = EXT_W'(-(2 ** (ACC_W - 2)));
  localparam logic signed [EXT_W-1:0] REP_MAX = EXT_W'((2 ** (DELTA_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] REP_MIN = EXT_W'(-(2 ** (DELTA_W - 1)));

  logic signed [ACC_W-1:0] acc;
  logic signed [EXT_W-1:0] accExt;
  logic signed [EXT_W-1:0] work;
  logic signed [EXT_W-1:0] limMax;
  logic signed [EXT_W-1:0] limMin;
  logic signed [EXT_W-1:0] clamped;

  assign accExt = EXT_W'(acc);

  // Value the host sees, clamped to the delta width.
  always_comb begin
    if (accExt > REP_MAX)      report = REP_MAX[DELTA_W-1:0];
    else if (accExt < REP_MIN) report = REP_MIN[DELTA_W-1:0];
    else                       report = acc[DELTA_W-1:0];
  end

  // Order of operations: clear, subtract the reported value, add the frame.
  always_comb begin
    work = clr ? '0 : accExt;
    if (sub) work = work - EXT_W'(report);
    if (add) work = work + EXT_W'(frameD);
  end

  assign limMax = hiRes ? HI_MAX : LO_MAX;
  assign limMin = hiRes ? HI_MIN : LO_MIN;

  always_comb begin
    satHit  = 1'b0;
    clamped = work;
    if (work > limMax) begin
      clamped = limMax;
      satHit  = 1'b1;
    end else if (work < limMin) begin
      clamped = limMin;
      satHit  = 1'b1;
    end
  end

  assign zeroNext = (clamped == '0);
  assign fitNext  = (clamped <= REP_MAX) && (clamped >= REP_MIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else       acc <= clamped[ACC_W-1:0];
  end

  // R4: a read with no frame and no clear never flips the sign of the accumulator.
  a_r4_drain_pos: assert property (@(posedge clk) disable iff (!rstN)
    (sub && !add && !clr && acc > 0) |=> (acc >= 0));
  a_r4_drain_neg: assert property (@(posedge clk) disable iff (!rstN)
    (sub && !add && !clr && acc < 0) |=> (acc <= 0));

endmodule

// File: rtl/mda_datapath.sv
module mda_datapath
  import mda_pkg::*;
#(
  parameter int ACC_W   = 13,
  parameter int DELTA_W = 8,
  parameter int IN_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hiRes,
  input  mda_strobe_t        strobe,
  input  logic [IN_W-1:0]    frameDx,
  input  logic [IN_W-1:0]    frameDy,
  output logic [DELTA_W-1:0] deltaX,
  output logic [DELTA_W-1:0] deltaY,
  output logic               satAny,
  output logic               bothZeroNext,
  output logic               bothFitNext
);

  logic signed [IN_W-1:0]    axIn  [NUM_AXES];
  logic signed [DELTA_W-1:0] axRep [NUM_AXES];
  logic [NUM_AXES-1:0]       axSub;
  logic [NUM_AXES-1:0]       axSat;
  logic [NUM_AXES-1:0]       axZero;
  logic [NUM_AXES-1:0]       axFit;

  assign axIn[AXIS_X]  = frameDx;
  assign axIn[AXIS_Y]  = frameDy;
  assign axSub[AXIS_X] = strobe.subX;
  assign axSub[AXIS_Y] = strobe.subY;

  for (genvar g = 0; g < NUM_AXES; g++) begin : gAxis
    mda_axis #(
      .ACC_W  (ACC_W),
      .DELTA_W(DELTA_W),
      .IN_W   (IN_W)
    ) uAxis (
      .clk     (clk),
      .rstN    (rstN),
      .hiRes   (hiRes),
      .clr     (strobe.clrAcc),
      .sub     (axSub[g]),
      .add     (strobe.addFrame),
      .frameD  (axIn[g]),
      .report  (axRep[g]),
      .satHit  (axSat[g]),
      .zeroNext(axZero[g]),
      .fitNext (axFit[g])
    );
  end

  assign deltaX       = axRep[AXIS_X];
  assign deltaY       = axRep[AXIS_Y];
  assign satAny       = |axSat;
  assign bothZeroNext = &axZero;
  assign bothFitNext  = &axFit;

endmodule

// File: rtl/mda_ctrl.sv
module mda_ctrl
  import mda_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameValid,
  input  logic [IN_W-1:0] frameDx,
  input  logic [IN_W-1:0] frameDy,
  input  logic            rdMotion,
  input  logic            rdDeltaX,
  input  logic            rdDeltaY,
  input  logic            wrMotion,
  input  logic            satAny,
  input  logic            bothZeroNext,
  input  logic            bothFitNext,
  output mda_strobe_t     strobe,
  output logic            motQ,
  output logic            ovfQ
);

  logic frameMoves;
  logic anyRead;

  assign frameMoves = frameValid && ((frameDx != '0) || (frameDy != '0));
  assign anyRead    = (rdDeltaX || rdDeltaY) && !wrMotion;

  always_comb begin
    strobe.clrAcc   = wrMotion;
    strobe.subX     = rdDeltaX && !wrMotion;
    strobe.subY     = rdDeltaY && !wrMotion;
    strobe.addFrame = frameValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      motQ <= 1'b0;
      ovfQ <= 1'b0;
    end else if (wrMotion) begin
      motQ <= frameMoves;
      ovfQ <= satAny;
    end else begin
      if (frameMoves)                    motQ <= 1'b1;
      else if (anyRead && bothZeroNext)  motQ <= 1'b0;
      if (satAny)                        ovfQ <= 1'b1;
      else if (anyRead && bothFitNext)   ovfQ <= 1'b0;
    end
  end

  // R8: a write leaves the overflow flag clear.
  a_r8_write_clears_ovf: assert property (@(posedge clk) disable iff (!rstN)
    wrMotion |=> !ovfQ);
  // R10: the motion flag falls only after a delta read or a write.
  a_r10_mot_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(motQ) |-> $past(wrMotion || rdDeltaX || rdDeltaY));
  // R6: the overflow flag rises only when a clamp happened.
  a_r6_ovf_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfQ) |-> $past(satAny));
  // R5: a nonzero frame always leaves the motion flag set.
  a_r5_frame_sets_mot: assert property (@(posedge clk) disable iff (!rstN)
    frameMoves |=> motQ);
  // R12: a bare status read keeps the motion flag.
  a_r12_status_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdMotion && !rdDeltaX && !rdDeltaY && !wrMotion && !frameValid) |=> (motQ == $past(motQ)));

endmodule

// File: rtl/motion_delta_accum.sv
module motion_delta_accum
  import mda_pkg::*;
#(
  parameter int ACC_W   = 13,
  parameter int DELTA_W = 8,
  parameter int IN_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hiRes,
  input  logic               frameValid,
  input  logic [IN_W-1:0]    frameDx,
  input  logic [IN_W-1:0]    frameDy,
  input  logic               rdMotion,
  input  logic               rdDeltaY,
  input  logic               rdDeltaX,
  input  logic               wrMotion,
  output logic [7:0]         statusByte,
  output logic [DELTA_W-1:0] deltaY,
  output logic [DELTA_W-1:0] deltaX,
  output logic               motionN
);

  mda_strobe_t strobe;
  logic satAny;
  logic bothZeroNext;
  logic bothFitNext;
  logic motQ;
  logic ovfQ;

  mda_ctrl #(.IN_W(IN_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameValid  (frameValid),
    .frameDx     (frameDx),
    .frameDy     (frameDy),
    .rdMotion    (rdMotion),
    .rdDeltaX    (rdDeltaX),
    .rdDeltaY    (rdDeltaY),
    .wrMotion    (wrMotion),
    .satAny      (satAny),
    .bothZeroNext(bothZeroNext),
    .bothFitNext (bothFitNext),
    .strobe      (strobe),
    .motQ        (motQ),
    .ovfQ        (ovfQ)
  );

  mda_datapath #(
    .ACC_W  (ACC_W),
    .DELTA_W(DELTA_W),
    .IN_W   (IN_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .hiRes       (hiRes),
    .strobe      (strobe),
    .frameDx     (frameDx),
    .frameDy     (frameDy),
    .deltaX      (deltaX),
    .deltaY      (deltaY),
    .satAny      (satAny),
    .bothZeroNext(bothZeroNext),
    .bothFitNext (bothFitNext)
  );

  // R2: flag layout, unused bits held at zero.
  assign statusByte = {motQ, 2'b00, ovfQ, 4'b0000};
  // R9: interrupt pin follows the motion flag, active low.
  assign motionN    = !motQ;

endmodule

// File: tb/tb_motion_delta_accum.sv
`timescale 1ns/1ps
module tb_motion_delta_accum;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hiRes = 1'b1;
  logic       frameValid = 1'b0;
  logic [7:0] frameDx = '0;
  logic [7:0] frameDy = '0;
  logic       rdMotion = 1'b0;
  logic       rdDeltaY = 1'b0;
  logic       rdDeltaX = 1'b0;
  logic       wrMotion = 1'b0;
  logic [7:0] statusByte;
  logic [7:0] deltaY;
  logic [7:0] deltaX;
  logic       motionN;

  always #5 clk = ~clk;

  motion_delta_accum dut (
    .clk(clk), .rstN(rstN), .hiRes(hiRes), .frameValid(frameValid),
    .frameDx(frameDx), .frameDy(frameDy), .rdMotion(rdMotion),
    .rdDeltaY(rdDeltaY), .rdDeltaX(rdDeltaX), .wrMotion(wrMotion),
    .statusByte(statusByte), .deltaY(deltaY), .deltaX(deltaX), .motionN(motionN)
  );

  typedef struct {
    string req;
    int    kind;   // 0 status, 1 pin, 2 X read value, 3 Y read value
    int    exp;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state built from the requirements.
  int mx = 0, my = 0;
  bit mot = 0, ovf = 0, hi = 1;

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // Monitor: compares queued expectations mid-cycle, away from the clock edge.
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      int act;
      it = expQ.pop_front();
      case (it.kind)
        0: act = int'(statusByte);
        1: act = int'(motionN);
        2: act = int'(deltaX);
        default: act = int'(deltaY);
      endcase
      checks++;
      if (act != (it.exp & 255)) begin
        errors++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp & 255);
      end
    end
  end

  // Driver: applies one cycle of stimulus, queues expectations, advances the model.
  task automatic step(input bit fv, input int dx, input int dy,
                      input bit rx, input bit ry, input bit rm, input bit wr,
                      input string req);
    int lo, hiL;
    bit clampAny;
    @(posedge clk); #2;
    frameValid = fv; frameDx = 8'(dx); frameDy = 8'(dy);
    rdDeltaX = rx; rdDeltaY = ry; rdMotion = rm; wrMotion = wr;
    hiRes = hi;
    expQ.push_back('{req, 0, (mot ? 128 : 0) + (ovf ? 16 : 0)});
    expQ.push_back('{req, 1, mot ? 0 : 1});
    if (rx) expQ.push_back('{req, 2, sat8(mx)});
    if (ry) expQ.push_back('{req, 3, sat8(my)});
    if (wr) begin
      mx = 0; my = 0;
    end else begin
      if (rx) mx -= sat8(mx);
      if (ry) my -= sat8(my);
    end
    if (fv) begin
      mx += dx; my += dy;
    end
    hiL = hi ? 4095 : 2047;
    lo  = hi ? -4096 : -2048;
    clampAny = 0;
    if (mx > hiL) begin mx = hiL; clampAny = 1; end
    if (mx < lo)  begin mx = lo;  clampAny = 1; end
    if (my > hiL) begin my = hiL; clampAny = 1; end
    if (my < lo)  begin my = lo;  clampAny = 1; end
    if (wr) begin
      mot = fv && (dx != 0 || dy != 0);
      ovf = clampAny;
    end else begin
      if (fv && (dx != 0 || dy != 0)) mot = 1;
      else if ((rx || ry) && mx == 0 && my == 0) mot = 0;
      if (clampAny) ovf = 1;
      else if ((rx || ry) && mx >= -128 && mx <= 127 && my >= -128 && my <= 127) ovf = 0;
    end
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic drainBoth(input string req);
    for (int i = 0; i < 40; i++) begin
      if (mx == 0 && my == 0) break;
      step(0, 0, 0, 1, 1, 0, 0, req);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 / R2 / R9: reset state seen at the ports.
    idle("R1");
    idle("R2");
    idle("R9");

    // R5, R3, R10: small frames, then reads back to zero.
    step(1, 5, -3, 0, 0, 0, 0, "R5");
    step(1, 2, 0, 0, 0, 0, 0, "R5");
    idle("R9");
    step(0, 0, 0, 0, 1, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 0, 0, "R10");
    idle("R10");

    // R12: status reads alone change nothing.
    step(1, -7, 9, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 0, "R12");
    step(0, 0, 0, 0, 0, 1, 0, "R12");
    step(0, 0, 0, 1, 1, 0, 0, "R12");
    idle("R12");

    // R4 / R3: large wide-range accumulation drained by repeated full-scale reads.
    for (int i = 0; i < 20; i++) step(1, 127, -100, 0, 0, 0, 0, "R4");
    drainBoth("R4");
    idle("R3");

    // R6 / R7: clamp at the high-resolution limit, overflow held until in range.
    for (int i = 0; i < 40; i++) step(1, 127, -128, 0, 0, 0, 0, "R6");
    idle("R6");
    drainBoth("R7");
    idle("R7");

    // R6: narrower range at low resolution.
    hi = 0;
    idle("R6");
    for (int i = 0; i < 20; i++) step(1, -127, 120, 0, 0, 0, 0, "R6");
    idle("R6");
    step(0, 0, 0, 1, 1, 0, 0, "R7");
    // R8: write discards motion and flags; a same-cycle frame survives.
    step(0, 0, 0, 0, 0, 0, 1, "R8");
    idle("R8");
    step(1, 40, 40, 0, 0, 0, 0, "R8");
    step(1, 3, -4, 0, 0, 0, 1, "R8");
    idle("R8");
    step(0, 0, 0, 1, 1, 0, 0, "R8");
    idle("R8");
    hi = 1;

    // R11: frame arriving with a read is added after the subtraction.
    for (int i = 0; i < 3; i++) step(1, 100, -90, 0, 0, 0, 0, "R11");
    step(1, 10, -10, 1, 1, 0, 0, "R11");
    step(1, 1, 1, 1, 0, 0, 0, "R11");
    step(1, -2, 0, 0, 1, 0, 0, "R11");
    drainBoth("R11");
    idle("R10");
    idle("R9");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule